// File: doc/BRIEF.md
# Shared-Period Multi-Channel PWM Generator

The block produces several pulse-width-modulated outputs from one timebase. A clock divider turns the input clock into slow ticks, and an 8-bit tick counter running over those ticks sets a period of 256 ticks. Every channel compares that shared counter against its own 8-bit duty value, so all outputs have the same period and start together, and each has its own high time. The high time is the duty value plus one tick. A duty of 0 gives a single-tick pulse and a duty of 255 keeps the output high.

Software programs the block through a plain 32-bit register bus: an address, a write strobe, write data, and combinational read data. One control word holds the divider setting and a single run bit for all channels. The 8-bit divider value is split across two nibbles that are not next to each other. A separate word holds an interrupt-enable flag, which is only stored. A new duty value is held back until the current period ends, so no pulse is cut short. Clearing the run bit parks the timebase at zero and drives every output low.

Top module: `pwm_bank`

## Requirements
- R1: After the synchronous active-low reset, every register reads 0 and every output is low.
- R2: Channel n's duty register sits at byte address 4*n, with the duty in bits 7:0. The control word sits at 0x50: divider bits 3:0 in bits 3:0, divider bits 7:4 in bits 14:11, and the run bit at bit 9. The interrupt-enable flag is bit 0 of the word at 0x54. Reads return the last written field values, and all other bits read 0. Addresses that map to no register read 0, and writes to them change nothing.
- R3: While running with divider value p, the period is 256*(p+1) input clock cycles.
- R4: A channel's output is high while the tick counter is at or below its duty value. Over one period, a duty d gives (d+1)*(p+1) high cycles.
- R5: A duty of 0 gives a high time of exactly one tick per period.
- R6: A duty of 255 keeps the output high for the whole time the block runs.
- R7: A write to a duty register that is running takes effect only when the counter wraps from 255 to 0. Until then, the output follows the old value.
- R8: While the run bit is clear, the divider and tick counter are held at 0 and all outputs are low. Setting the run bit starts a period at count 0 with the latest duty values.
- R9: All channels share one period and start together. Each channel's high time depends only on its own duty value.
- R10: The interrupt-enable flag is stored and read back, and it has no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_we | input | 1 | Write strobe, sampled at the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pwm_out | output | NCH | One PWM output per channel |

## Verification
Four channels are programmed with the duties 0, 255, 127 and 3. With these values the single-tick minimum, the never-low maximum and two middle values each produce a different high count, so an error in the compare boundary shows up on at least one channel. The divider is run at 0, at 2, and at a value whose upper nibble is set (0x13). These settings separate a correct period length from an off-by-one divider and from a wrong nibble placement. A duty rewrite in mid-period, a stop and restart, and toggles of the interrupt flag are each checked cycle by cycle against a model. These cases tell deferred loading apart from immediate loading, and show whether the timebase resets cleanly and whether the stored-only flag leaks into the outputs.

// File: rtl/pwm_bank_pkg.sv
// Shared constants and types for the PWM bank: register offsets, the
// positions of fields the control decoder relies on, and counter widths.
package pwm_bank_pkg;
    localparam int unsigned CNT_W      = 8;     // tick counter and duty width
    localparam int unsigned PSC_W      = 8;     // divider setting width
    localparam int unsigned NIB_W      = 4;     // one divider nibble
    localparam int unsigned DATA_W     = 32;    // bus word width
    localparam int unsigned STRIDE     = 4;     // bytes between duty words
    localparam int unsigned CTRL_OFS   = 'h50;  // control word offset
    localparam int unsigned IRQ_OFS    = 'h54;  // interrupt-enable word offset
    localparam int unsigned PSC_LO_LSB = 0;     // divider bits 3:0 position
    localparam int unsigned PSC_HI_LSB = 11;    // divider bits 7:4 position
    localparam int unsigned RUN_BIT    = 9;     // shared run bit
    localparam int unsigned IRQ_BIT    = 0;     // interrupt-enable bit

    typedef struct packed {
        logic [PSC_W-1:0] divide;   // ticks last divide+1 input clocks
        logic             run;      // shared run bit
        logic             irq_en;   // stored only
    } pwm_cfg_t;
endpackage

// File: rtl/pwm_bank_regs.sv
// Register file and bus decode for the PWM bank.
// Assumes: byte addresses, whole-word writes, one duty word per channel at
// STRIDE*n. NCH*STRIDE must stay below CTRL_OFS. Read data is combinational.
module pwm_bank_regs
    import pwm_bank_pkg::*;
#(
    parameter int unsigned NCH    = 1,
    parameter int unsigned ADDR_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     addr,
    input  logic                  we,
    input  logic [DATA_W-1:0]     wdata,
    output logic [DATA_W-1:0]     rdata,
    output pwm_cfg_t              cfg,
    output logic [NCH*CNT_W-1:0]  duty_flat
);
    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFS);
    localparam logic [ADDR_W-1:0] IRQ_A  = ADDR_W'(IRQ_OFS);

    pwm_cfg_t          cfg_q;
    logic [CNT_W-1:0]  duty_q [NCH];

    // Control and interrupt-enable words: update on a write to their address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (we) begin
            if (addr == CTRL_A) begin
                cfg_q.divide <= {wdata[PSC_HI_LSB +: NIB_W], wdata[PSC_LO_LSB +: NIB_W]};
                cfg_q.run    <= wdata[RUN_BIT];
            end
            if (addr == IRQ_A) begin
                cfg_q.irq_en <= wdata[IRQ_BIT];
            end
        end
    end

    // Per-channel duty words: each captures the low byte written to its slot.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NCH; i++) begin
            if (!rst_n) begin
                duty_q[i] <= '0;
            end else if (we && addr == ADDR_W'(STRIDE * i)) begin
                duty_q[i] <= wdata[CNT_W-1:0];
            end
        end
    end

    // Read mux: place each field at its bit position, everything else zero.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NCH; i++) begin
            if (addr == ADDR_W'(STRIDE * i)) begin
                rdata[CNT_W-1:0] = duty_q[i];
            end
        end
        if (addr == CTRL_A) begin
            rdata[PSC_LO_LSB +: NIB_W] = cfg_q.divide[NIB_W-1:0];
            rdata[PSC_HI_LSB +: NIB_W] = cfg_q.divide[PSC_W-1:NIB_W];
            rdata[RUN_BIT]             = cfg_q.run;
        end
        if (addr == IRQ_A) begin
            rdata[IRQ_BIT] = cfg_q.irq_en;
        end
    end

    // Flatten duty words for the channel slices.
    always_comb begin
        for (int i = 0; i < NCH; i++) begin
            duty_flat[i*CNT_W +: CNT_W] = duty_q[i];
        end
    end

    assign cfg = cfg_q;
endmodule

// File: rtl/pwm_bank_timebase.sv
// Shared timebase: a clock divider that produces ticks, and an 8-bit tick
// counter that wraps every 256 ticks. Assumes a divider setting that changes
// while running takes effect on the next compare (>= keeps it from overrunning).
module pwm_bank_timebase
    import pwm_bank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [PSC_W-1:0]  divide,
    output logic [PSC_W-1:0]  div_cnt,
    output logic [CNT_W-1:0]  tick_cnt,
    output logic              period_end
);
    logic advance;

    // A tick completes when the divider has counted divide+1 input clocks.
    assign advance    = run && (div_cnt >= divide);
    assign period_end = advance && (tick_cnt == {CNT_W{1'b1}});

    // Divider and tick counter: parked at zero while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            div_cnt  <= '0;
            tick_cnt <= '0;
        end else if (advance) begin
            div_cnt  <= '0;
            tick_cnt <= tick_cnt + 1'b1;
        end else begin
            div_cnt  <= div_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/pwm_bank_chan.sv
// One PWM channel: an active duty copy that reloads from the programmed value
// only at a period end or while stopped, and a compare against the tick count.
module pwm_bank_chan
    import pwm_bank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              period_end,
    input  logic [CNT_W-1:0]  duty_prog,
    input  logic [CNT_W-1:0]  tick_cnt,
    output logic [CNT_W-1:0]  duty_act,
    output logic              pwm
);
    // Active duty: take the programmed value at a period boundary or when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            duty_act <= '0;
        end else if (!run || period_end) begin
            duty_act <= duty_prog;
        end
    end

    // Output is high from count 0 through the active duty value.
    assign pwm = run && (tick_cnt <= duty_act);
endmodule

// File: rtl/pwm_bank.sv
// Top of the PWM bank: register decode, one shared timebase and NCH channels.
// Assumes a single clock domain and a synchronous active-low reset.
module pwm_bank
    import pwm_bank_pkg::*;
#(
    parameter int unsigned NCH    = 1,
    parameter int unsigned ADDR_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_we,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic [NCH-1:0]     pwm_out
);
    pwm_cfg_t              cfg;
    logic [NCH*CNT_W-1:0]  duty_flat;
    logic [NCH*CNT_W-1:0]  act_flat;
    logic [PSC_W-1:0]      div_cnt;
    logic [CNT_W-1:0]      tick_cnt;
    logic                  period_end;
    logic                  run_w;

    assign run_w = cfg.run;

    pwm_bank_regs #(.NCH(NCH), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (bus_addr),
        .we        (bus_we),
        .wdata     (bus_wdata),
        .rdata     (bus_rdata),
        .cfg       (cfg),
        .duty_flat (duty_flat)
    );

    pwm_bank_timebase u_tb (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run_w),
        .divide     (cfg.divide),
        .div_cnt    (div_cnt),
        .tick_cnt   (tick_cnt),
        .period_end (period_end)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        pwm_bank_chan u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .run        (run_w),
            .period_end (period_end),
            .duty_prog  (duty_flat[i*CNT_W +: CNT_W]),
            .tick_cnt   (tick_cnt),
            .duty_act   (act_flat[i*CNT_W +: CNT_W]),
            .pwm        (pwm_out[i])
        );
    end
endmodule

// File: rtl/pwm_bank_chk.sv
// Checker for the PWM bank, bound into every instance of the top module.
// Relates the run bit, the timebase counters, active duties and outputs.
module pwm_bank_chk
    import pwm_bank_pkg::*;
#(
    parameter int unsigned NCH = 1
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  run,
    input logic [PSC_W-1:0]      div_cnt,
    input logic [CNT_W-1:0]      tick_cnt,
    input logic [NCH*CNT_W-1:0]  act_flat,
    input logic [NCH-1:0]        pwm_out
);
    // R8: stopped means all outputs low.
    assert_off_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (pwm_out == '0));

    // R8: one cycle after being stopped the timebase is at zero.
    assert_off_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (div_cnt == '0 && tick_cnt == '0));

    // R3: while running, the tick counter only ever steps by one.
    assert_tick_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && tick_cnt != $past(tick_cnt))
            |-> (tick_cnt == $past(tick_cnt) + 8'd1));

    // R3: a tick step restarts the divider.
    assert_div_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && tick_cnt != $past(tick_cnt)) |-> (div_cnt == '0));

    for (genvar i = 0; i < NCH; i++) begin : g_chk
        // R7: while running, the active duty changes only across the 255->0 wrap.
        assert_duty_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (run && $past(run) && act_flat[i*CNT_W +: CNT_W] != $past(act_flat[i*CNT_W +: CNT_W]))
                |-> ($past(tick_cnt) == 8'hFF && tick_cnt == 8'h00));

        // R6: full-scale duty never lets the output drop while running.
        assert_full_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (run && act_flat[i*CNT_W +: CNT_W] == 8'hFF) |-> pwm_out[i]);

        // R5: zero duty is high only at count zero.
        assert_zero_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (run && act_flat[i*CNT_W +: CNT_W] == 8'h00 && tick_cnt != 8'h00) |-> !pwm_out[i]);
    end
endmodule

bind pwm_bank pwm_bank_chk #(.NCH(NCH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run_w),
    .div_cnt  (div_cnt),
    .tick_cnt (tick_cnt),
    .act_flat (act_flat),
    .pwm_out  (pwm_out)
);

// File: tb/pwm_bank_tb.sv
// Scoreboard bench: a reference model pushes the expected output vector each
// cycle into a queue, and a monitor pops and compares it on the falling edge.
module pwm_bank_tb;
    localparam int NCH    = 4;
    localparam int ADDR_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_we = 1'b0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [NCH-1:0]    pwm_out;

    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    pwm_bank #(.NCH(NCH), .ADDR_W(ADDR_W)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pwm_out   (pwm_out)
    );

    // Reference model state, built from the requirements.
    logic [7:0] m_div, m_pc, m_tc;
    logic       m_run, m_irq;
    logic [7:0] m_duty [NCH];
    logic [7:0] m_act  [NCH];
    logic [NCH-1:0] exp_q [$];

    // Model: advance one input clock and push the expected outputs.
    always @(posedge clk) begin
        logic adv, pend;
        logic [NCH-1:0] e;
        if (!rst_n) begin
            m_div = 0; m_pc = 0; m_tc = 0; m_run = 0; m_irq = 0;
            for (int i = 0; i < NCH; i++) begin m_duty[i] = 0; m_act[i] = 0; end
        end else begin
            adv  = m_run && (m_pc >= m_div);
            pend = adv && (m_tc == 8'hFF);
            for (int i = 0; i < NCH; i++) if (!m_run || pend) m_act[i] = m_duty[i];
            if (!m_run) begin m_pc = 0; m_tc = 0; end
            else if (adv) begin m_pc = 0; m_tc = m_tc + 8'd1; end
            else m_pc = m_pc + 8'd1;
            if (bus_we) begin
                for (int i = 0; i < NCH; i++) if (bus_addr == 8'(4*i)) m_duty[i] = bus_wdata[7:0];
                if (bus_addr == 8'h50) begin
                    m_div = {bus_wdata[14:11], bus_wdata[3:0]};
                    m_run = bus_wdata[9];
                end
                if (bus_addr == 8'h54) m_irq = bus_wdata[0];
            end
        end
        e = '0;
        for (int i = 0; i < NCH; i++) e[i] = m_run && (m_tc <= m_act[i]);
        exp_q.push_back(e);
    end

    // Monitor: compare the outputs with the model every cycle (R1 R4 R7 R9 R10).
    always @(negedge clk) begin
        logic [NCH-1:0] e;
        if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            n_cmp++;
            if (pwm_out !== e) begin
                n_bad++;
                $display("FAIL R4/R7/R9 scoreboard t=%0t actual=%b expected=%b", $time, pwm_out, e);
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_read_check(input logic [7:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        bus_addr = a;
        #1;
        check(bus_rdata === exp, req, "readback", bus_rdata, exp);
    endtask

    function automatic logic [31:0] ctrl_word(input bit run, input logic [7:0] div);
        return (32'(div[3:0])) | (32'(div[7:4]) << 11) | (32'(run) << 9);
    endfunction

    task automatic high_count(input int ch, input int ncyc, output int n);
        n = 0;
        for (int k = 0; k < ncyc; k++) begin
            @(negedge clk);
            #1;
            if (pwm_out[ch]) n++;
        end
    endtask

    task automatic wait_rise(input int ch);
        logic prev;
        @(negedge clk); #1;
        prev = pwm_out[ch];
        forever begin
            @(negedge clk); #1;
            if (pwm_out[ch] && !prev) break;
            prev = pwm_out[ch];
        end
    endtask

    task automatic period_of(input int ch, output int n);
        logic prev;
        wait_rise(ch);
        prev = 1'b1;
        n = 0;
        forever begin
            @(negedge clk); #1;
            n++;
            if (pwm_out[ch] && !prev) break;
            prev = pwm_out[ch];
        end
    endtask

    task automatic summary;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state of every register and the outputs.
        for (int i = 0; i < NCH; i++) bus_read_check(8'(4*i), 32'h0, "R1");
        bus_read_check(8'h50, 32'h0, "R1");
        bus_read_check(8'h54, 32'h0, "R1");
        check(pwm_out === '0, "R1", "outputs low", 32'(pwm_out), 0);

        // R2: field placement, unused bits read zero.
        bus_write(8'h50, 32'hFFFF_FDFF);
        bus_read_check(8'h50, 32'h0000_780F, "R2");
        bus_write(8'h50, 32'h0);
        bus_write(8'h54, 32'hFFFF_FFFF);
        bus_read_check(8'h54, 32'h1, "R2");
        bus_write(8'h00, 32'hABCD_EF00);
        bus_write(8'h04, 32'h1234_56FF);
        bus_write(8'h08, 32'h0000_007F);
        bus_write(8'h0C, 32'hFFFF_FF03);
        bus_read_check(8'h00, 32'h00, "R2");
        bus_read_check(8'h04, 32'hFF, "R2");
        bus_read_check(8'h08, 32'h7F, "R2");
        bus_read_check(8'h0C, 32'h03, "R2");
        // R2: unmapped addresses read zero and writes there change nothing.
        bus_write(8'h40, 32'hFFFF_FFFF);
        bus_write(8'h58, 32'hFFFF_FFFF);
        bus_read_check(8'h40, 32'h0, "R2");
        bus_read_check(8'h58, 32'h0, "R2");
        bus_read_check(8'h08, 32'h7F, "R2");
        bus_read_check(8'h50, 32'h0, "R2");

        // R8: start; first cycle is count 0 with all duties, all channels high.
        bus_write(8'h50, ctrl_word(1'b1, 8'd0));
        #1;
        check(pwm_out === 4'hF, "R8", "first tick after start", 32'(pwm_out), 32'hF);
        @(negedge clk); #1;
        check(pwm_out === 4'hE, "R5", "zero duty drops after one tick", 32'(pwm_out), 32'hE);

        // R3/R4/R5/R6/R9 at divider 0.
        period_of(2, n);
        check(n == 256, "R3", "period at divider 0", 32'(n), 256);
        high_count(0, 256, n); check(n == 1,   "R5", "ch0 high count", 32'(n), 1);
        high_count(1, 256, n); check(n == 256, "R6", "ch1 high count", 32'(n), 256);
        high_count(2, 256, n); check(n == 128, "R4", "ch2 high count", 32'(n), 128);
        high_count(3, 256, n); check(n == 4,   "R9", "ch3 high count", 32'(n), 4);

        // R7: mid-period duty rewrite; the scoreboard checks each cycle.
        wait_rise(2);
        repeat (20) @(negedge clk);
        bus_write(8'h08, 32'd10);
        #1;
        check(pwm_out[2] === 1'b1, "R7", "old duty still applies", 32'(pwm_out[2]), 1);
        repeat (300) @(negedge clk);
        high_count(2, 256, n); check(n == 11, "R7", "new duty after wrap", 32'(n), 11);

        // R3/R4 at divider 2.
        bus_write(8'h50, ctrl_word(1'b1, 8'd2));
        wait_rise(2);
        period_of(2, n);
        check(n == 768, "R3", "period at divider 2", 32'(n), 768);
        high_count(2, 768, n); check(n == 33, "R4", "ch2 high at divider 2", 32'(n), 33);
        high_count(0, 768, n); check(n == 3,  "R5", "ch0 one tick at divider 2", 32'(n), 3);

        // R2/R3: upper nibble of the divider (0x13 -> 20 clocks per tick).
        bus_write(8'h50, ctrl_word(1'b1, 8'h13));
        bus_read_check(8'h50, 32'h0000_0A03, "R2");
        wait_rise(2);
        period_of(2, n);
        check(n == 5120, "R3", "period at divider 0x13", 32'(n), 5120);

        // R10: interrupt flag has no effect on the outputs.
        bus_write(8'h50, ctrl_word(1'b1, 8'd0));
        bus_write(8'h54, 32'h0);
        bus_read_check(8'h54, 32'h0, "R10");
        repeat (300) @(negedge clk);
        high_count(3, 256, n); check(n == 4, "R10", "ch3 with flag clear", 32'(n), 4);
        bus_write(8'h54, 32'h1);
        high_count(3, 256, n); check(n == 4, "R10", "ch3 with flag set", 32'(n), 4);

        // R8: stop holds all outputs low, even the full-scale channel.
        bus_write(8'h50, 32'h0);
        high_count(1, 300, n); check(n == 0, "R8", "ch1 low while stopped", 32'(n), 0);
        check(pwm_out === '0, "R8", "all low while stopped", 32'(pwm_out), 0);
        bus_write(8'h50, ctrl_word(1'b1, 8'd0));
        #1;
        check(pwm_out === 4'hF, "R8", "restart at count 0", 32'(pwm_out), 32'hF);
        repeat (600) @(negedge clk);

        summary();
        $finish;
    end
endmodule